// File: doc/BRIEF.md
# Hierarchical Cluster Packet Router

This block steers packets for one member of a cluster of up to 32 nodes. The member has three bidirectional links to other members and one local path to its own processor. Every link and the local path carry valid/ready word streams with a last-word flag. The first word of a packet is its header, and bits [4:0] of that header hold the 5-bit destination node address. The router looks only at the header to choose where the packet goes. All later words of the packet follow that same choice until the word flagged as last.

Nodes are arranged in groups of four. A node's group is its address bits [4:2] and its place in the group is bits [1:0]. A packet that arrives on a link and is addressed to this node goes to the local deliver output. Otherwise it is forwarded. Inside the group, the previous-neighbour link carries packets for lower positions and the next-neighbour link carries packets for higher positions. Packets for any other group leave on the group link. The node address and the three link roles (each a link index 0..2) are captured from plain configuration pins on a load strobe at start-up.

Each link has three buffers: a send buffer for locally injected packets, a receive buffer for packets addressed to this node, and a forward buffer for packets in transit. When several sources want the same output, a round-robin arbiter hands out that output one packet at a time, so packets never interleave. Back-pressure rules apply to every stream port. A sender holds valid, data and last stable until ready is seen high at a clock edge. The router lowers ready on an input when the buffer its current packet is going to is full, and it never drops a word. A router output that is valid keeps its word stable until the receiver accepts it.

Top module: `rtr_cluster_router`

## Requirements
- R1: A packet that arrives on a link with header destination (bits [4:0]) equal to the node address is presented whole on the deliver output and on no link output.
- R2: A link packet for the same group (equal address bits [4:2]) with a lower in-group position (bits [1:0]) leaves on the previous-neighbour link.
- R3: A link packet for the same group with a higher in-group position leaves on the next-neighbour link.
- R4: A packet whose destination is in a different group leaves on the group link.
- R5: The node address and the three link roles are captured only when cfg_load is high. After reset they are address 0, previous link 0, next link 1 and group link 2. Changing the configuration pins while cfg_load is low does not change routing.
- R6: Every word of a packet follows the header's output in order, and an output never interleaves words from two packets.
- R7: When more than one source holds a packet for the same output, the output is granted round-robin at packet boundaries. Two sources that keep competing are served in alternation.
- R8: No word is lost. When the buffer chosen for an input's current packet is full, that input's ready is low until space frees up.
- R9: Packets injected on the local send input are routed by the rules of R2 to R4. A local packet addressed to this node itself leaves on the next-neighbour link.
- R10: After reset no output is valid, and all inputs are ready.
- R11: A valid output word, with its data and last flag, stays unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Capture strobe for the configuration pins |
| cfg_node_addr | input | 5 | Address of this node |
| cfg_prev_link | input | 2 | Link index toward the lower neighbour in the group |
| cfg_next_link | input | 2 | Link index toward the higher neighbour in the group |
| cfg_group_link | input | 2 | Link index toward the neighbouring group |
| rx_valid | input | 3 | Per-link inbound word valid |
| rx_ready | output | 3 | Per-link inbound ready |
| rx_data | input | 3xDW | Per-link inbound word |
| rx_last | input | 3 | Per-link inbound last-word flag |
| tx_valid | output | 3 | Per-link outbound word valid |
| tx_ready | input | 3 | Per-link outbound ready |
| tx_data | output | 3xDW | Per-link outbound word |
| tx_last | output | 3 | Per-link outbound last-word flag |
| snd_valid | input | 1 | Local send word valid |
| snd_ready | output | 1 | Local send ready |
| snd_data | input | DW | Local send word |
| snd_last | input | 1 | Local send last-word flag |
| dlv_valid | output | 1 | Local deliver word valid |
| dlv_ready | input | 1 | Local deliver ready |
| dlv_data | output | DW | Local deliver word |
| dlv_last | output | 1 | Local deliver last-word flag |

## Verification
The bench targets the address comparison at its edges. It uses destinations one position below and one above this node, the node's own address, and addresses in lower and higher groups. A router that compared full addresses instead of in-group positions, or that mixed up the previous and next roles, would put packets on the wrong link. The bench holds an output stalled while two sources queue packets for it. If the grants were not rotated at packet boundaries, the completed packet sequence would not alternate; if the output were released mid-packet, words would interleave. The bench also starves one output until an input's forward buffer fills, to confirm that the input's ready falls instead of words vanishing. It rewrites the configuration pins without the load strobe to confirm that routing stays unchanged.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  localparam int ADDR_W = 5;
  localparam int NLINK  = 3;

  // Choose the outbound link for a destination, given this node's address
  // and the link roles; group = upper bits, position = two low bits.
  function automatic logic [1:0] pick_link(
    input logic [ADDR_W-1:0] dest,
    input logic [ADDR_W-1:0] me,
    input logic [1:0]        prv,
    input logic [1:0]        nxt,
    input logic [1:0]        grp
  );
    if (dest[ADDR_W-1:2] != me[ADDR_W-1:2]) return grp;
    else if (dest[1:0] < me[1:0])           return prv;
    else                                    return nxt;
  endfunction
endpackage

// File: rtl/rtr_fifo.sv
module rtr_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (rd_en) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R8: the writer must honour full, the reader must honour empty
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);
endmodule

// File: rtl/rtr_steer.sv
module rtr_steer
  import rtr_pkg::*;
#(
  parameter bit LINK_IN = 1'b1,
  parameter int NOUT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [ADDR_W-1:0] hdr_dest,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] me,
  input  logic [1:0]        prv,
  input  logic [1:0]        nxt,
  input  logic [1:0]        grp,
  input  logic [NOUT-1:0]   full,
  output logic [NOUT-1:0]   wr,
  output logic [1:0]        port
);
  localparam int SW = (NOUT > 1) ? $clog2(NOUT) : 1;

  logic [SW-1:0] sel_now, sel_q, sel;
  logic [1:0]    port_now, port_q;
  logic          in_pkt;

  assign port_now = pick_link(hdr_dest, me, prv, nxt, grp);

  generate
    if (LINK_IN) begin : g_link
      // target 1 = local receive buffer, target 0 = forward buffer
      assign sel_now = SW'(hdr_dest == me);
    end else begin : g_local
      assign sel_now = SW'(port_now);
    end
  endgenerate

  assign sel      = in_pkt ? sel_q  : sel_now;
  assign port     = in_pkt ? port_q : port_now;
  assign in_ready = !full[sel];

  always_comb begin
    for (int i = 0; i < NOUT; i++)
      wr[i] = in_valid && in_ready && (sel == SW'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt <= 1'b0;
      sel_q  <= '0;
      port_q <= '0;
    end else if (in_valid && in_ready) begin
      in_pkt <= !in_last;
      sel_q  <= sel;
      port_q <= port;
    end
  end

  // R6: the body of a packet keeps the header's target
  a_r6_route_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_last) |=> (sel == $past(sel)) && (port == $past(port)));
endmodule

// File: rtl/rtr_rr_mux.sv
module rtr_rr_mux #(
  parameter int N  = 4,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         in_valid,
  input  logic [N-1:0][DW-1:0] in_data,
  input  logic [N-1:0]         in_last,
  output logic [N-1:0]         in_pop,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DW-1:0]        out_data,
  output logic                 out_last
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic          locked, any;
  logic [IW-1:0] owner, ptr, pick;

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = 0; i < N; i++) begin
      int c;
      c = (int'(ptr) + i) % N;
      if (!any && in_valid[c]) begin
        any  = 1'b1;
        pick = IW'(c);
      end
    end
  end

  assign out_valid = locked && in_valid[owner];
  assign out_data  = in_data[owner];
  assign out_last  = in_last[owner];

  always_comb begin
    for (int i = 0; i < N; i++)
      in_pop[i] = locked && (owner == IW'(i)) && in_valid[i] && out_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      owner  <= '0;
      ptr    <= '0;
    end else if (!locked) begin
      if (any) begin
        locked <= 1'b1;
        owner  <= pick;
      end
    end else if (out_valid && out_ready && out_last) begin
      locked <= 1'b0;
      ptr    <= (owner == IW'(N - 1)) ? '0 : owner + 1'b1;
    end
  end

  // R11: a stalled word does not change
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last));
  // R6: the grant stays with one source until its last word leaves
  a_r6_owner_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !(out_valid && out_ready && out_last)) |=> locked && $stable(owner));
  // R7: at most one source is drained per cycle
  a_r7_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_pop));
endmodule

// File: rtl/rtr_cluster_router.sv
module rtr_cluster_router
  import rtr_pkg::*;
#(
  parameter int DW         = 32,
  parameter int HDR_LSB    = 0,
  parameter int FWD_DEPTH  = 4,
  parameter int SEND_DEPTH = 4,
  parameter int LRX_DEPTH  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_load,
  input  logic [4:0]             cfg_node_addr,
  input  logic [1:0]             cfg_prev_link,
  input  logic [1:0]             cfg_next_link,
  input  logic [1:0]             cfg_group_link,
  input  logic [2:0]             rx_valid,
  output logic [2:0]             rx_ready,
  input  logic [2:0][DW-1:0]     rx_data,
  input  logic [2:0]             rx_last,
  output logic [2:0]             tx_valid,
  input  logic [2:0]             tx_ready,
  output logic [2:0][DW-1:0]     tx_data,
  output logic [2:0]             tx_last,
  input  logic                   snd_valid,
  output logic                   snd_ready,
  input  logic [DW-1:0]          snd_data,
  input  logic                   snd_last,
  output logic                   dlv_valid,
  input  logic                   dlv_ready,
  output logic [DW-1:0]          dlv_data,
  output logic                   dlv_last
);
  localparam int NL = NLINK;
  localparam int LW = DW + 1;
  localparam int FW = DW + 3;

  // configuration captured at start-up
  logic [ADDR_W-1:0] me_q;
  logic [1:0]        prv_q, nxt_q, grp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      me_q  <= '0;
      prv_q <= 2'd0;
      nxt_q <= 2'd1;
      grp_q <= 2'd2;
    end else if (cfg_load) begin
      me_q  <= cfg_node_addr;
      prv_q <= cfg_prev_link;
      nxt_q <= cfg_next_link;
      grp_q <= cfg_group_link;
    end
  end

  logic [NL-1:0][FW-1:0]  fwd_head;
  logic [NL-1:0]          fwd_empty, fwd_full, fwd_wr, fwd_rd;
  logic [NL-1:0][1:0]     lk_port;
  logic [NL-1:0][1:0]     lk_wr, lk_full;
  logic [NL-1:0][LW-1:0]  lrx_head, snd_head;
  logic [NL-1:0]          lrx_empty, lrx_full, lrx_wr, lrx_rd;
  logic [NL-1:0]          snd_empty, snd_full, snd_wr, snd_rd;
  logic [1:0]             snd_port;
  logic [NL-1:0][NL:0]    tx_pop;
  logic [NL-1:0][NL:0]    mx_v, mx_l;
  logic [NL-1:0][NL:0][DW-1:0] mx_d;
  logic [NL-1:0]          dv_v, dv_l;
  logic [NL-1:0][DW-1:0]  dv_d;

  // local send path: one steering stage into the three send buffers
  rtr_steer #(.LINK_IN(1'b0), .NOUT(NL)) u_snd_steer (
    .clk, .rst_n,
    .in_valid(snd_valid), .in_last(snd_last),
    .hdr_dest(snd_data[HDR_LSB +: ADDR_W]), .in_ready(snd_ready),
    .me(me_q), .prv(prv_q), .nxt(nxt_q), .grp(grp_q),
    .full(snd_full), .wr(snd_wr), .port(snd_port)
  );

  generate
    for (genvar k = 0; k < NL; k++) begin : g_link
      assign lk_full[k] = {lrx_full[k], fwd_full[k]};
      assign fwd_wr[k]  = lk_wr[k][0];
      assign lrx_wr[k]  = lk_wr[k][1];

      rtr_steer #(.LINK_IN(1'b1), .NOUT(2)) u_steer (
        .clk, .rst_n,
        .in_valid(rx_valid[k]), .in_last(rx_last[k]),
        .hdr_dest(rx_data[k][HDR_LSB +: ADDR_W]), .in_ready(rx_ready[k]),
        .me(me_q), .prv(prv_q), .nxt(nxt_q), .grp(grp_q),
        .full(lk_full[k]), .wr(lk_wr[k]), .port(lk_port[k])
      );

      rtr_fifo #(.W(FW), .DEPTH(FWD_DEPTH)) u_fwd (
        .clk, .rst_n,
        .wr_en(fwd_wr[k]), .wr_data({lk_port[k], rx_last[k], rx_data[k]}),
        .full(fwd_full[k]), .rd_en(fwd_rd[k]), .rd_data(fwd_head[k]),
        .empty(fwd_empty[k])
      );

      rtr_fifo #(.W(LW), .DEPTH(LRX_DEPTH)) u_lrx (
        .clk, .rst_n,
        .wr_en(lrx_wr[k]), .wr_data({rx_last[k], rx_data[k]}),
        .full(lrx_full[k]), .rd_en(lrx_rd[k]), .rd_data(lrx_head[k]),
        .empty(lrx_empty[k])
      );

      rtr_fifo #(.W(LW), .DEPTH(SEND_DEPTH)) u_snd (
        .clk, .rst_n,
        .wr_en(snd_wr[k]), .wr_data({snd_last, snd_data}),
        .full(snd_full[k]), .rd_en(snd_rd[k]), .rd_data(snd_head[k]),
        .empty(snd_empty[k])
      );

      // output k sources: 0 = own send buffer, 1+j = forward buffer j
      assign mx_v[k][0] = !snd_empty[k];
      assign mx_d[k][0] = snd_head[k][DW-1:0];
      assign mx_l[k][0] = snd_head[k][DW];
      for (genvar j = 0; j < NL; j++) begin : g_src
        assign mx_v[k][j+1] = !fwd_empty[j] && (fwd_head[j][FW-1 -: 2] == 2'(k));
        assign mx_d[k][j+1] = fwd_head[j][DW-1:0];
        assign mx_l[k][j+1] = fwd_head[j][DW];
      end

      rtr_rr_mux #(.N(NL + 1), .DW(DW)) u_tx_mux (
        .clk, .rst_n,
        .in_valid(mx_v[k]), .in_data(mx_d[k]), .in_last(mx_l[k]),
        .in_pop(tx_pop[k]),
        .out_valid(tx_valid[k]), .out_ready(tx_ready[k]),
        .out_data(tx_data[k]), .out_last(tx_last[k])
      );
      assign snd_rd[k] = tx_pop[k][0];

      assign dv_v[k] = !lrx_empty[k];
      assign dv_d[k] = lrx_head[k][DW-1:0];
      assign dv_l[k] = lrx_head[k][DW];
    end
  endgenerate

  always_comb begin
    fwd_rd = '0;
    for (int j = 0; j < NL; j++)
      for (int k = 0; k < NL; k++)
        fwd_rd[j] = fwd_rd[j] | tx_pop[k][j+1];
  end

  rtr_rr_mux #(.N(NL), .DW(DW)) u_dlv_mux (
    .clk, .rst_n,
    .in_valid(dv_v), .in_data(dv_d), .in_last(dv_l), .in_pop(lrx_rd),
    .out_valid(dlv_valid), .out_ready(dlv_ready),
    .out_data(dlv_data), .out_last(dlv_last)
  );

  // R5: routing state moves only on the load strobe
  a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(me_q) && $stable(prv_q) && $stable(nxt_q) && $stable(grp_q));
  // R1: a header addressed to this node never enters a forward buffer
  a_r1_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_wr[0] && !$past(rx_valid[0] && rx_ready[0] && !rx_last[0]))
      |-> (rx_data[0][HDR_LSB +: ADDR_W] != me_q));
  // R9: a local write lands only in the send buffer of the chosen link
  a_r9_send_port: assert property (@(posedge clk) disable iff (!rst_n)
    (|snd_wr) |-> $onehot(snd_wr) && snd_wr[snd_port]);
endmodule

// File: tb/tb_rtr_cluster_router.sv
module tb_rtr_cluster_router;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n, cfg_load;
  logic [4:0]      cfg_node_addr;
  logic [1:0]      cfg_prev_link, cfg_next_link, cfg_group_link;
  logic [2:0]      rx_valid, rx_ready, rx_last, tx_valid, tx_ready, tx_last;
  logic [2:0][31:0] rx_data, tx_data;
  logic            snd_valid, snd_ready, snd_last, dlv_valid, dlv_ready, dlv_last;
  logic [31:0]     snd_data, dlv_data;

  rtr_cluster_router dut (.*);

  // bench configuration: node 9 = group 2, position 1
  localparam int ME = 9, PRV = 2, NXT = 0, GRP = 1;

  int    n_chk = 0, n_fail = 0;
  int    exp_port [256];
  int    exp_len  [256];
  int    exp_src  [256];
  string exp_tag  [256];
  bit    sent [256];
  bit    done [256];
  int    ordq [4][$];
  bit    rnd_en = 1'b0;

  task automatic chk(bit ok, string tag, int act, int exp, string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int route_of(int src, int dest);
    if (src < 3 && dest == ME) return 3;
    if (dest / 4 != ME / 4)    return GRP;
    if (dest % 4 < ME % 4)     return PRV;
    return NXT;
  endfunction

  function automatic string tag_of(int src, int dest);
    if (src == 3)              return "R9";
    if (dest == ME)            return "R1";
    if (dest / 4 != ME / 4)    return "R4";
    if (dest % 4 < ME % 4)     return "R2";
    return "R3";
  endfunction

  function automatic bit rdy(int src);
    return (src < 3) ? rx_ready[src] : snd_ready;
  endfunction

  task automatic drive(int src, bit v, logic [31:0] w, bit l);
    if (src < 3) begin
      rx_valid[src] = v; rx_data[src] = w; rx_last[src] = l;
    end else begin
      snd_valid = v; snd_data = w; snd_last = l;
    end
  endtask

  // driver: registers the expected packet in the scoreboard, then streams it
  task automatic send_pkt(int src, int id, int dest, int len, string tag);
    exp_port[id] = route_of(src, dest);
    exp_len[id]  = len;
    exp_src[id]  = src;
    exp_tag[id]  = (tag == "") ? tag_of(src, dest) : tag;
    done[id]     = 1'b0;
    sent[id]     = 1'b1;
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      bit acc;
      drive(src, 1'b1, {id[7:0], i[7:0], 11'b0, dest[4:0]}, i == len - 1);
      acc = 1'b0;
      while (!acc) begin
        #5 acc = rdy(src);
        @(negedge clk);
      end
    end
    drive(src, 1'b0, '0, 1'b0);
  endtask

  // monitor: one scoreboard per output (0..2 links, 3 deliver)
  int cur_id [4];
  int cur_idx [4];
  bit busy [4];
  always begin
    @(negedge clk);
    #5;
    if (rst_n) begin
      for (int o = 0; o < 4; o++) begin
        bit v, l;
        logic [31:0] w;
        int id, idx;
        v = (o < 3) ? (tx_valid[o] && tx_ready[o]) : (dlv_valid && dlv_ready);
        w = (o < 3) ? tx_data[o] : dlv_data;
        l = (o < 3) ? tx_last[o] : dlv_last;
        if (v) begin
          id  = int'(w[31:24]);
          idx = int'(w[23:16]);
          if (!busy[o]) begin
            chk(sent[id] && exp_port[id] == o, sent[id] ? exp_tag[id] : "R6", o, exp_port[id],
                "packet output");
            busy[o]    = 1'b1;
            cur_id[o]  = id;
            cur_idx[o] = 0;
          end
          // R6: contiguous, ordered words with last only on the final one
          chk(id == cur_id[o] && idx == cur_idx[o] && (l == (idx == exp_len[id] - 1)),
              "R6", idx, cur_idx[o], "word order/contiguity");
          cur_idx[o]++;
          if (l) begin
            busy[o]  = 1'b0;
            done[id] = 1'b1;
            ordq[o].push_back(id);
          end
        end
      end
    end
  end

  always begin
    @(negedge clk);
    if (rnd_en) begin
      tx_ready  = 3'($urandom);
      dlv_ready = 1'($urandom);
    end
  end

  task automatic drain();
    bit all;
    for (int c = 0; c < 3000; c++) begin
      all = 1'b1;
      for (int i = 0; i < 256; i++) if (sent[i] && !done[i]) all = 1'b0;
      if (all) break;
      @(negedge clk);
    end
  endtask

  task automatic rand_src(int src, int base);
    for (int n = 0; n < 10; n++) begin
      send_pkt(src, base + n, $urandom_range(0, 31), $urandom_range(1, 5), "");
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R8 watchdog expired: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d0;
    bit          v0;
    int          id;
    for (int i = 0; i < 256; i++) begin sent[i] = 0; done[i] = 0; end
    for (int o = 0; o < 4; o++) busy[o] = 0;
    rst_n = 0; cfg_load = 0;
    cfg_node_addr = '0; cfg_prev_link = '0; cfg_next_link = '0; cfg_group_link = '0;
    rx_valid = '0; rx_data = '0; rx_last = '0;
    snd_valid = 0; snd_data = '0; snd_last = 0;
    tx_ready = '0; dlv_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #5;
    // R10: idle outputs and open inputs after reset
    chk(tx_valid == 3'b000 && !dlv_valid, "R10", {tx_valid, dlv_valid}, 0, "valid after reset");
    chk(rx_ready == 3'b111 && snd_ready, "R10", {rx_ready, snd_ready}, 15, "ready after reset");

    @(negedge clk);
    tx_ready = 3'b111; dlv_ready = 1;
    cfg_node_addr = 5'(ME); cfg_prev_link = 2'(PRV);
    cfg_next_link = 2'(NXT); cfg_group_link = 2'(GRP);
    cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;

    // R1..R4: link traffic at the comparison edges
    id = 1;
    send_pkt(0, id++, 9, 3, "");   // R1 own address
    send_pkt(1, id++, 8, 2, "");   // R2 one position lower
    send_pkt(2, id++, 11, 4, "");  // R3 two positions higher
    send_pkt(0, id++, 10, 1, "");  // R3 one position higher
    send_pkt(1, id++, 20, 3, "");  // R4 higher group
    send_pkt(2, id++, 3, 2, "");   // R4 lower group
    send_pkt(2, id++, 9, 1, "");   // R1 single-word packet
    // R9: locally injected packets
    send_pkt(3, id++, 10, 2, "");
    send_pkt(3, id++, 8, 3, "");
    send_pkt(3, id++, 30, 2, "");
    send_pkt(3, id++, 9, 2, "");   // self-addressed leaves on next link
    drain();

    // R5: pins change without the strobe; routing must not move
    cfg_node_addr = 5'd20; cfg_prev_link = 2'd1; cfg_next_link = 2'd2; cfg_group_link = 2'd0;
    send_pkt(0, id++, 8, 2, "R5");
    send_pkt(1, id++, 9, 2, "R5");
    drain();

    // R8: starve link 2 until link 1's forward buffer fills
    tx_ready[2] = 1'b0;
    fork
      begin
        for (int n = 0; n < 4; n++) send_pkt(1, 30 + n, 8, 3, "R8");
      end
    join_none
    repeat (40) @(negedge clk);
    #5;
    chk(rx_ready[1] == 1'b0, "R8", rx_ready[1], 0, "ready while forward buffer full");
    @(negedge clk);
    tx_ready[2] = 1'b1;
    wait fork;
    drain();

    // R7/R11: two sources queue for stalled link 1, then release
    ordq[1].delete();
    tx_ready[1] = 1'b0;
    fork
      begin send_pkt(3, 50, 30, 2, "R7"); send_pkt(3, 51, 30, 2, "R7"); end
      begin send_pkt(2, 52, 20, 2, "R7"); send_pkt(2, 53, 20, 2, "R7"); end
    join_none
    repeat (20) @(negedge clk);
    #5;
    v0 = tx_valid[1]; d0 = tx_data[1];
    repeat (5) @(negedge clk);
    #5;
    chk(v0 && tx_valid[1] && tx_data[1] == d0, "R11", int'(tx_data[1]), int'(d0),
        "stalled word stable");
    @(negedge clk);
    tx_ready[1] = 1'b1;
    wait fork;
    drain();
    chk(ordq[1].size() == 4, "R7", ordq[1].size(), 4, "packets on contended output");
    if (ordq[1].size() == 4)
      for (int i = 1; i < 4; i++)
        chk(exp_src[ordq[1][i]] != exp_src[ordq[1][i-1]], "R7",
            exp_src[ordq[1][i]], exp_src[ordq[1][i-1]], "source alternation");

    // R6/R8: all sources at once, random back-pressure
    rnd_en = 1'b1;
    fork
      rand_src(0, 100);
      rand_src(1, 120);
      rand_src(2, 140);
      rand_src(3, 160);
    join
    rnd_en = 1'b0;
    @(negedge clk);
    tx_ready = 3'b111; dlv_ready = 1;
    drain();

    // R8: nothing lost anywhere
    for (int i = 0; i < 256; i++)
      if (sent[i]) chk(done[i], "R8", done[i], 1, $sformatf("packet %0d delivered", i));

    summary();
    $finish;
  end
endmodule